// File: doc/BRIEF.md
# Soft-Start and Soft-Stop Reference Sequencer

This block sequences the shared reference of a dual-channel step-down controller. It runs on the system clock and moves forward only on a one-cycle switching tick. It produces a 6-bit reference code that both channels' DAC take. When enable goes high, the code climbs from zero to full scale. When enable goes low, the code runs back down the same way, and the converter powers off only after the code has returned to zero.

The block also outputs a switching enable, a 2-bit gate-state command for the driver stage, and a request to discharge the compensation node. Its active-low reset output reports when the supply is good. Under-voltage and over-temperature flags override the sequence at once. When they clear with enable still high, a fresh ramp starts from code zero.

Top module: `ref_seq`

## Requirements
- R1: During a ramp the code changes by exactly one step for every 16 tick pulses. No other step sizes occur. A full ramp in either direction lasts 1024 ticks.
- R2: With no fault present, enable going high starts an up-ramp from the current code. The code climbs to 63, and after 16 more ticks the sequence is complete.
- R3: Enable going low starts a down-ramp. The code falls to 0, and after 16 more ticks the block enters shutdown. Until that moment the drivers stay switching (gate_st = 00).
- R4: In shutdown with no fault, gate_st = 11 (switch node released), comp_dis = 1, sw_en = 0 and the code is 0.
- R5: While uv = 1, gate_st = 01 (low-side on), sw_en = 0 and rst_out_n = 0. The code is cleared to 0 on the next clock.
- R6: While ot = 1 and uv = 0, gate_st = 10 (both drives low), sw_en = 0 and rst_out_n = 0. The ramp progress is cleared, so the code is 0 on the next clock.
- R7: rst_out_n is 0 whenever pg_a = 0 or pg_b = 0.
- R8: rst_out_n is 1 only when pg_a = 1, pg_b = 1, no fault is present and the up-ramp is complete.
- R9: If enable returns high during a down-ramp, the code turns around and climbs from its current value. It does not restart from 0.
- R10: When a fault clears while enable is high, a new up-ramp starts from code 0 on the next clock.
- R11: sw_en is 1 exactly when gate_st = 00.

Priority when several conditions hold at once: uv, then ot, then shutdown, then switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per switching cycle |
| en | input | 1 | Converter enable |
| uv | input | 1 | Supply under-voltage flag |
| ot | input | 1 | Over-temperature flag |
| pg_a | input | 1 | Channel A output above 90% of nominal |
| pg_b | input | 1 | Channel B output above 90% of nominal |
| dac_code | output | 6 | Shared reference DAC code |
| sw_en | output | 1 | Switching enable for the modulator |
| gate_st | output | 2 | Driver command: 00 switching, 01 UV, 10 both low, 11 released |
| comp_dis | output | 1 | Compensation node discharge request |
| rst_out_n | output | 1 | Active-low supply-good reset |

## Verification
Some events can land on the same clock as a code step or as a ramp end. An enable edge can fall in the cycle where a tick completes a step. A fault can rise while a step is due. A down-ramp can reach code 0 in the cycle where enable comes back. The bench provokes these cases by running the tick every cycle and every third cycle, then toggling enable and the fault flags after ramp lengths chosen to hit these boundaries. A behavioural model decides each cycle whether the step, the turnaround or the fault took effect, and every output is compared on every clock.

// File: rtl/ref_seq.sv
module ref_seq #(
  parameter int CODE_W     = 6,
  parameter int STEP_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              uv,
  input  logic              ot,
  input  logic              pg_a,
  input  logic              pg_b,
  output logic [CODE_W-1:0] dac_code,
  output logic              sw_en,
  output logic [1:0]        gate_st,
  output logic              comp_dis,
  output logic              rst_out_n
);
  localparam int PRE_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(STEP_TICKS - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  typedef enum logic [1:0] {S_OFF, S_UP, S_ON, S_DN} st_t;

  st_t              st;
  logic [PRE_W-1:0] pre;
  logic [CODE_W-1:0] code;
  logic             step;

  assign step = tick && (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      pre  <= '0;
      code <= '0;
    end else if (uv || ot) begin
      st   <= S_OFF;
      pre  <= '0;
      code <= '0;
    end else begin
      case (st)
        S_OFF: if (en) begin
          st  <= S_UP;
          pre <= '0;
        end
        S_UP: if (!en) begin
          st  <= S_DN;
          pre <= '0;
        end else if (tick) begin
          if (step) begin
            pre <= '0;
            if (code == CODE_MAX) st <= S_ON;
            else code <= code + 1'b1;
          end else pre <= pre + 1'b1;
        end
        S_ON: if (!en) begin
          st  <= S_DN;
          pre <= '0;
        end
        S_DN: if (en) begin
          st  <= S_UP;
          pre <= '0;
        end else if (tick) begin
          if (step) begin
            pre <= '0;
            if (code == '0) st <= S_OFF;
            else code <= code - 1'b1;
          end else pre <= pre + 1'b1;
        end
        default: st <= S_OFF;
      endcase
    end
  end

  assign dac_code  = code;
  assign gate_st   = uv ? 2'b01 : ot ? 2'b10 : (st == S_OFF) ? 2'b11 : 2'b00;
  assign sw_en     = (gate_st == 2'b00);
  assign comp_dis  = (gate_st == 2'b11);
  assign rst_out_n = sw_en && (st == S_ON) && pg_a && pg_b;
endmodule

// File: rtl/ref_seq_chk.sv
module ref_seq_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uv,
  input logic              ot,
  input logic              pg_a,
  input logic              pg_b,
  input logic [CODE_W-1:0] dac_code,
  input logic              sw_en,
  input logic [1:0]        gate_st,
  input logic              comp_dis,
  input logic              rst_out_n
);
  localparam logic [CODE_W:0] FULL = {1'b0, {CODE_W{1'b1}}};

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!uv && !ot) |-> ({1'b0, dac_code} == {1'b0, $past(dac_code)} ||
                           {1'b0, dac_code} == {1'b0, $past(dac_code)} + 1'b1 ||
                           {1'b0, dac_code} + 1'b1 == {1'b0, $past(dac_code)})); // R1
  AST_UV_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    uv |-> (gate_st == 2'b01 && !sw_en && !rst_out_n)); // R5
  AST_OT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ot) |-> (dac_code == '0)); // R6
  AST_PG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_a || !pg_b) |-> !rst_out_n); // R7
  AST_RST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |-> ({1'b0, dac_code} == FULL && sw_en)); // R8
  AST_OFF_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    comp_dis |-> (dac_code == '0 && !sw_en)); // R4
endmodule

bind ref_seq ref_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uv(uv), .ot(ot), .pg_a(pg_a), .pg_b(pg_b),
  .dac_code(dac_code), .sw_en(sw_en), .gate_st(gate_st),
  .comp_dis(comp_dis), .rst_out_n(rst_out_n)
);

// File: tb/ref_seq_test.sv
module ref_seq_test;
  logic clk = 0, rst_n = 0, tick = 0, en = 0, uv = 0, ot = 0, pg_a = 0, pg_b = 0;
  logic [5:0] dac_code;
  logic sw_en, comp_dis, rst_out_n;
  logic [1:0] gate_st;

  int checks = 0, fails = 0, cyc = 0, tick_div = 1;
  bit done = 0;

  // model: mode 0 shutdown, 1 rising, 2 complete, 3 falling
  int m_mode = 0, m_lvl = 0, m_sub = 0;

  always #2.5 clk = ~clk;

  ref_seq uut (.clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .uv(uv), .ot(ot),
               .pg_a(pg_a), .pg_b(pg_b), .dac_code(dac_code), .sw_en(sw_en),
               .gate_st(gate_st), .comp_dis(comp_dis), .rst_out_n(rst_out_n));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || uv || ot) begin
      m_mode = 0; m_lvl = 0; m_sub = 0;
    end else if (m_mode == 0) begin
      if (en) begin m_mode = 1; m_sub = 0; end
    end else if (m_mode == 2) begin
      if (!en) begin m_mode = 3; m_sub = 0; end
    end else if ((m_mode == 1) != en) begin
      m_mode = en ? 1 : 3; m_sub = 0;
    end else if (tick) begin
      m_sub++;
      if (m_sub == 16) begin
        m_sub = 0;
        if (m_mode == 1) begin
          if (m_lvl == 63) m_mode = 2; else m_lvl++;
        end else begin
          if (m_lvl == 0) m_mode = 0; else m_lvl--;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    int g;
    g = uv ? 1 : ot ? 2 : (m_mode == 0) ? 3 : 0;
    chk("R1/R2/R3/R9/R10 dac_code", dac_code, m_lvl);
    chk("R4/R5/R6 gate_st", gate_st, g);
    chk("R11 sw_en", sw_en, g == 0);
    chk("R4 comp_dis", comp_dis, g == 3);
    chk("R7/R8 rst_out_n", rst_out_n, (g == 0 && m_mode == 2 && pg_a && pg_b));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      cyc++;
      tick = (tick_div == 1) || (cyc % tick_div == 0);
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick = 1;
    run(3);                       // reset state, R4
    rst_n = 1;
    run(5);                       // shutdown with enable low, R4
    en = 1; pg_a = 1; pg_b = 1;
    run(1100);                    // R2 ramp up, R1 step timing, R8 release
    pg_a = 0; run(5);             // R7
    pg_a = 1; pg_b = 0; run(5);   // R7
    pg_b = 1; run(3);
    en = 0; run(1100);            // R3 ramp down into shutdown
    en = 1; run(300);
    en = 0; run(100);
    en = 1; run(1200);            // R9 turnaround from mid code
    uv = 1; run(10);              // R5
    ot = 1; run(4);               // R5 over R6 priority
    uv = 0; run(6);               // R6
    ot = 0; run(400);             // R10 restart from zero
    ot = 1; run(5);               // R6 progress cleared mid ramp
    ot = 0; run(1030);            // R10
    en = 0; run(1024);            // R3 completion boundary
    en = 1; run(2);
    en = 0; run(40);
    tick_div = 3;
    en = 1; run(3200);            // R1 gapped ticks
    en = 0; run(1000);
    en = 1; run(500);             // R9
    uv = 1; run(3);               // R5
    uv = 0; run(20);              // R10
    en = 0; run(3200);            // R3, R4
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule